// File: doc/BRIEF.md
# Multi-Channel Memory-to-Memory DMA Controller

This block copies data inside memory for software. Each channel has its own register slot. The slot holds a source address, a destination address, a count of transfer units and a control word. One shared operation register holds a global enable and two error flags.

Software fills in a channel's slot and sets the channel's enable bit. From then on the engine moves one unit per grant over a single-beat memory master port, as a read beat followed by a write beat. When the channel's count reaches zero, the engine raises a per-channel end flag, and an end interrupt if that channel allows it.

If an address does not suit the selected unit size, the error flag in the shared register is set and every channel stops. An external non-maskable event pulse also sets a flag and stops every channel. Software clears the flags and sets the global enable again to resume the pending work. When several channels are ready, the lowest index always goes first.

Top module: `mdma_ctrl`

## Requirements
- R1: After reset every control word reads 0x320: unit size field 2 (4 bytes), source increment bit 8 set, destination increment bit 9 set, enable bit 0, end flag bit 1 and interrupt-enable bit 2 all clear. Addresses, counts and the operation register read 0, and both interrupt outputs are low.
- R2: With OPR_SLOT = 2, the operation register sits at byte offset 0x20. Channel c starts at c*0x10 when c < 2 and at (c+1)*0x10 otherwise. Within a slot, +0x0 is the source, +0x4 the destination, +0x8 the count and +0xC the control word. reg_addr is a word address, which is the byte offset divided by 4.
- R3: The count is kept in units, not bytes. It drops by exactly one per completed unit for every unit size. A count of 0 written with the enable bit set moves 2^CW units.
- R4: When the count reaches zero, the end flag (control bit 1) is set and the channel issues no more beats. Writing 0 to that bit clears it. Writing 1 to it has no effect.
- R5: end_irq[c] is high exactly while channel c has both its end flag and its interrupt-enable bit set. Clearing the interrupt-enable bit drops the interrupt.
- R6: Control bits [5:4] select the unit size: 0 is 1 byte, 1 is 2 bytes, 2 is 4 bytes and 3 is 16 bytes. A 16-byte unit moves as four 4-byte beat pairs at offsets 0, 4, 8 and 12. After each unit, an address whose increment bit is set advances by the unit size. An address whose increment bit is clear stays where it is.
- R7: Each beat pair is a read beat followed, in the next cycle, by a write beat. mem_size is 0, 1 or 2 for 1, 2 or 4 bytes. Data on the port is right-justified. mem_rdata must be valid in the cycle after the read beat, and that value is written back unchanged.
- R8: Ready channels are served by fixed priority, lowest index first, and arbitration takes place again before every unit.
- R9: In the operation register, bit 0 is the global enable, bit 1 is the event flag and bit 2 is the address-error flag. Units start only while bit 0 is 1 and both flags are 0. Only hardware sets the flags. Writing 0 to a flag clears it, and writing 1 leaves it unchanged.
- R10: If a channel about to start has a source or destination address that is not a multiple of its unit size, the address-error flag is set, err_irq goes high, the global enable is cleared, no beat is issued and the channel's registers keep their values. A one-cycle nmi_in pulse sets the event flag and clears the global enable.
- R11: Once the flags are cleared and the global enable is set again, channels that are still enabled and not ended resume.
- R12: If the enable bit is cleared in the middle of a transfer, the unit in flight completes and no further unit starts. The count register then holds the number of units still to move.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | RAW-2 | Register word address |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from reg_addr |
| nmi_in | input | 1 | Non-maskable event pulse |
| mem_valid | output | 1 | Memory beat valid |
| mem_we | output | 1 | Beat is a write |
| mem_addr | output | AW | Beat byte address |
| mem_size | output | 2 | Beat size code |
| mem_wdata | output | 32 | Write data, right-justified |
| mem_rdata | input | 32 | Read data, valid the cycle after a read beat |
| end_irq | output | NCH | Per-channel end interrupt |
| err_irq | output | 1 | Address-error interrupt |

## Verification
Internal errors show up at the memory port within one to four cycles. A wrong address step, a wrong size code or lost data corrupts the very next write beat. A wrong priority decision puts another channel's beat first in the sequence. A count or end-flag error appears either as an extra or missing write beat at the end of a transfer, or as a wrong end_irq level once the transfer has drained. A halt that fails to hold shows up as a write beat while the operation register reports an error.

// File: rtl/mdma_pkg.sv
package mdma_pkg;
   typedef enum logic [1:0] {SZ_B = 2'd0, SZ_H = 2'd1, SZ_W = 2'd2, SZ_Q = 2'd3} usize_t;
   typedef enum logic [1:0] {EN_IDLE = 2'd0, EN_RD = 2'd1, EN_WR = 2'd2} est_t;

   // control word bit positions
   localparam int CB_DE   = 0;
   localparam int CB_TE   = 1;
   localparam int CB_IE   = 2;
   localparam int CB_SZ   = 4;
   localparam int CB_SINC = 8;
   localparam int CB_DINC = 9;
   // operation register bit positions
   localparam int OB_INIT = 0;
   localparam int OB_NMIF = 1;
   localparam int OB_AE   = 2;

   function automatic logic [4:0] unit_bytes(usize_t s);
      case (s)
         SZ_B:    return 5'd1;
         SZ_H:    return 5'd2;
         SZ_W:    return 5'd4;
         default: return 5'd16;
      endcase
   endfunction

   function automatic logic misaligned(logic [3:0] a, usize_t s);
      case (s)
         SZ_B:    return 1'b0;
         SZ_H:    return a[0];
         SZ_W:    return |a[1:0];
         default: return |a;
      endcase
   endfunction
endpackage

// File: rtl/mdma_chan.sv
module mdma_chan
   import mdma_pkg::*;
#(
   parameter int AW = 32,
   parameter int CW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          wr_en,
   input  logic [1:0]    wr_sel,
   input  logic [31:0]   wr_data,
   input  logic          step,
   output logic [AW-1:0] src_o,
   output logic [AW-1:0] dst_o,
   output logic [CW-1:0] cnt_o,
   output logic [31:0]   ctrl_o,
   output usize_t        sz_o,
   output logic          req_o
);
   logic [AW-1:0] src, dst;
   logic [CW-1:0] cnt;
   logic          de, te, ie, sinc, dinc;
   usize_t        sz;
   logic [AW-1:0] unit;
   logic          last;

   assign unit = AW'(unit_bytes(sz));
   assign last = (cnt == CW'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         src  <= '0;
         dst  <= '0;
         cnt  <= '0;
         de   <= 1'b0;
         te   <= 1'b0;
         ie   <= 1'b0;
         sz   <= SZ_W;
         sinc <= 1'b1;
         dinc <= 1'b1;
      end else begin
         if (step) begin
            if (sinc) src <= src + unit;
            if (dinc) dst <= dst + unit;
            cnt <= cnt - CW'(1);
         end
         if (wr_en) begin
            case (wr_sel)
               2'd0: src <= wr_data[AW-1:0];
               2'd1: dst <= wr_data[AW-1:0];
               2'd2: cnt <= wr_data[CW-1:0];
               default: begin
                  de   <= wr_data[CB_DE];
                  ie   <= wr_data[CB_IE];
                  sz   <= usize_t'(wr_data[CB_SZ+1:CB_SZ]);
                  sinc <= wr_data[CB_SINC];
                  dinc <= wr_data[CB_DINC];
                  if (!wr_data[CB_TE]) te <= 1'b0;
               end
            endcase
         end
         if (step && last) te <= 1'b1;
      end
   end

   assign src_o = src;
   assign dst_o = dst;
   assign cnt_o = cnt;
   assign sz_o  = sz;
   assign req_o = de & ~te;

   always_comb begin
      ctrl_o = '0;
      ctrl_o[CB_DE]            = de;
      ctrl_o[CB_TE]            = te;
      ctrl_o[CB_IE]            = ie;
      ctrl_o[CB_SZ+1:CB_SZ]    = sz;
      ctrl_o[CB_SINC]          = sinc;
      ctrl_o[CB_DINC]          = dinc;
   end

   // R4
   te_on_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (step && last) |=> te);

   // R3
   cnt_unit_dec_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !wr_en) |=> (cnt == CW'($past(cnt) - CW'(1))));
endmodule

// File: rtl/mdma_prio.sv
module mdma_prio #(
   parameter int N  = 4,
   parameter int IW = 2
) (
   input  logic [N-1:0]  req,
   output logic [IW-1:0] idx,
   output logic          any
);
   always_comb begin
      idx = '0;
      for (int i = N - 1; i >= 0; i--) begin
         if (req[i]) idx = IW'(i);
      end
   end
   assign any = |req;
endmodule

// File: rtl/mdma_engine.sv
module mdma_engine
   import mdma_pkg::*;
#(
   parameter int AW = 32,
   parameter int IW = 2
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          req_any,
   input  logic [IW-1:0] req_idx,
   input  logic [AW-1:0] sel_src,
   input  logic [AW-1:0] sel_dst,
   input  usize_t        sel_sz,
   output logic [IW-1:0] sel_idx,
   output logic          ae_set,
   output logic          step,
   output logic          mem_valid,
   output logic          mem_we,
   output logic [AW-1:0] mem_addr,
   output logic [1:0]    mem_size,
   output logic [31:0]   mem_wdata,
   input  logic [31:0]   mem_rdata
);
   est_t          state;
   logic [IW-1:0] cur;
   logic [1:0]    beat;
   logic          last_beat, bad;
   logic [AW-1:0] offs;

   assign last_beat = (sel_sz != SZ_Q) || (beat == 2'd3);
   assign bad       = misaligned(sel_src[3:0], sel_sz) | misaligned(sel_dst[3:0], sel_sz);
   assign sel_idx   = (state == EN_IDLE) ? req_idx : cur;
   assign ae_set    = (state == EN_IDLE) && req_any && bad;
   assign step      = (state == EN_WR) && last_beat;
   assign offs      = AW'({beat, 2'b00});

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= EN_IDLE;
         cur   <= '0;
         beat  <= '0;
      end else begin
         case (state)
            EN_IDLE: if (req_any && !bad) begin
               cur   <= req_idx;
               beat  <= '0;
               state <= EN_RD;
            end
            EN_RD: state <= EN_WR;
            EN_WR: begin
               if (last_beat) state <= EN_IDLE;
               else begin
                  beat  <= beat + 2'd1;
                  state <= EN_RD;
               end
            end
            default: state <= EN_IDLE;
         endcase
      end
   end

   assign mem_valid = (state != EN_IDLE);
   assign mem_we    = (state == EN_WR);
   assign mem_addr  = (state == EN_WR) ? sel_dst + offs : sel_src + offs;
   assign mem_size  = (sel_sz == SZ_Q) ? SZ_W : sel_sz;
   assign mem_wdata = mem_rdata;

   // R7
   rd_then_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_valid && !mem_we) |=> (mem_valid && mem_we));

   // R10
   word_align_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_valid && mem_size == 2'd2) |-> (mem_addr[1:0] == 2'b00));
endmodule

// File: rtl/mdma_ctrl.sv
module mdma_ctrl
   import mdma_pkg::*;
#(
   parameter int NCH      = 4,
   parameter int AW       = 32,
   parameter int CW       = 8,
   parameter int OPR_SLOT = 2,
   localparam int IW      = (NCH > 1) ? $clog2(NCH) : 1,
   localparam int RAW     = $clog2((NCH + 1) * 16)
) (
   input  logic           clk,
   input  logic           rst_n,
   input  logic           reg_we,
   input  logic [RAW-3:0] reg_addr,
   input  logic [31:0]    reg_wdata,
   output logic [31:0]    reg_rdata,
   input  logic           nmi_in,
   output logic           mem_valid,
   output logic           mem_we,
   output logic [AW-1:0]  mem_addr,
   output logic [1:0]     mem_size,
   output logic [31:0]    mem_wdata,
   input  logic [31:0]    mem_rdata,
   output logic [NCH-1:0] end_irq,
   output logic           err_irq
);
   localparam int SW = RAW - 4;
   localparam logic [SW-1:0] OPS = SW'(OPR_SLOT);

   if (NCH < 1 || NCH > 8)         begin : bad_nch  $error("NCH out of range"); end
   if (OPR_SLOT < 0 || OPR_SLOT > NCH) begin : bad_slot $error("OPR_SLOT out of range"); end
   if (AW < 8 || AW > 32)          begin : bad_aw   $error("AW out of range"); end
   if (CW < 2 || CW > 24)          begin : bad_cw   $error("CW out of range"); end

   logic [SW-1:0] slot, ch_of_slot;
   logic          is_op, ch_ok;
   logic [IW-1:0] chx;

   assign slot       = reg_addr[RAW-3:2];
   assign is_op      = (slot == OPS);
   assign ch_of_slot = (slot > OPS) ? slot - SW'(1) : slot;
   assign ch_ok      = !is_op && (ch_of_slot < SW'(NCH));
   assign chx        = ch_of_slot[IW-1:0];

   logic          op_init, op_nmif, op_ae, op_ok;
   logic [AW-1:0] src_a  [NCH];
   logic [AW-1:0] dst_a  [NCH];
   logic [CW-1:0] cnt_a  [NCH];
   logic [31:0]   ctrl_a [NCH];
   usize_t        sz_a   [NCH];
   logic [NCH-1:0] req_raw, req_v, step_v;
   logic [IW-1:0] arb_idx, eng_idx;
   logic          arb_any, ae_set, step;

   assign op_ok = op_init & ~op_nmif & ~op_ae;

   for (genvar i = 0; i < NCH; i++) begin : g_ch
      mdma_chan #(.AW(AW), .CW(CW)) u_chan (
         .clk     (clk),
         .rst_n   (rst_n),
         .wr_en   (reg_we && ch_ok && (ch_of_slot == SW'(i))),
         .wr_sel  (reg_addr[1:0]),
         .wr_data (reg_wdata),
         .step    (step_v[i]),
         .src_o   (src_a[i]),
         .dst_o   (dst_a[i]),
         .cnt_o   (cnt_a[i]),
         .ctrl_o  (ctrl_a[i]),
         .sz_o    (sz_a[i]),
         .req_o   (req_raw[i])
      );
      assign req_v[i]   = req_raw[i] & op_ok;
      assign step_v[i]  = step && (eng_idx == IW'(i));
      assign end_irq[i] = ctrl_a[i][CB_TE] & ctrl_a[i][CB_IE];
   end

   mdma_prio #(.N(NCH), .IW(IW)) u_prio (
      .req (req_v),
      .idx (arb_idx),
      .any (arb_any)
   );

   mdma_engine #(.AW(AW), .IW(IW)) u_eng (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_any   (arb_any),
      .req_idx   (arb_idx),
      .sel_src   (src_a[eng_idx]),
      .sel_dst   (dst_a[eng_idx]),
      .sel_sz    (sz_a[eng_idx]),
      .sel_idx   (eng_idx),
      .ae_set    (ae_set),
      .step      (step),
      .mem_valid (mem_valid),
      .mem_we    (mem_we),
      .mem_addr  (mem_addr),
      .mem_size  (mem_size),
      .mem_wdata (mem_wdata),
      .mem_rdata (mem_rdata)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         op_init <= 1'b0;
         op_nmif <= 1'b0;
         op_ae   <= 1'b0;
      end else begin
         if (reg_we && is_op) begin
            op_init <= reg_wdata[OB_INIT];
            if (!reg_wdata[OB_NMIF]) op_nmif <= 1'b0;
            if (!reg_wdata[OB_AE])   op_ae   <= 1'b0;
         end
         if (nmi_in) begin
            op_nmif <= 1'b1;
            op_init <= 1'b0;
         end
         if (ae_set) begin
            op_ae   <= 1'b1;
            op_init <= 1'b0;
         end
      end
   end

   assign err_irq = op_ae;

   always_comb begin
      reg_rdata = '0;
      if (is_op) begin
         reg_rdata[OB_INIT] = op_init;
         reg_rdata[OB_NMIF] = op_nmif;
         reg_rdata[OB_AE]   = op_ae;
      end else if (ch_ok) begin
         case (reg_addr[1:0])
            2'd0:    reg_rdata = 32'(src_a[chx]);
            2'd1:    reg_rdata = 32'(dst_a[chx]);
            2'd2:    reg_rdata = 32'(cnt_a[chx]);
            default: reg_rdata = ctrl_a[chx];
         endcase
      end
   end

   // R10
   err_drops_init_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(op_ae) |-> !op_init);

   // R9
   halt_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ((op_ae || op_nmif || !op_init) && !mem_valid) |=> !mem_valid);
endmodule

// File: tb/mdma_ctrl_test.sv
module mdma_ctrl_test;
   localparam int NCH = 4, AW = 32, CW = 8, RAW = 7;

   logic           clk = 1'b0, rst_n = 1'b0;
   logic           reg_we = 1'b0;
   logic [RAW-3:0] reg_addr = '0;
   logic [31:0]    reg_wdata = '0, reg_rdata;
   logic           nmi_in = 1'b0;
   logic           mem_valid, mem_we;
   logic [AW-1:0]  mem_addr;
   logic [1:0]     mem_size;
   logic [31:0]    mem_wdata, mem_rdata = '0;
   logic [NCH-1:0] end_irq;
   logic           err_irq;

   mdma_ctrl #(.NCH(NCH), .AW(AW), .CW(CW), .OPR_SLOT(2)) uut (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .nmi_in(nmi_in),
      .mem_valid(mem_valid), .mem_we(mem_we), .mem_addr(mem_addr),
      .mem_size(mem_size), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
      .end_irq(end_irq), .err_irq(err_irq));

   always #5 clk = ~clk;

   int tests = 0, fails = 0, wcount = 0;
   bit track = 1'b1, done = 1'b0;
   logic [7:0]  mem [0:4095];
   logic [63:0] expq [$];

   task automatic chk(string tag, logic [63:0] act, logic [63:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   function automatic logic [31:0] rmem(logic [31:0] a, logic [1:0] s);
      logic [11:0] b = a[11:0];
      case (s)
         2'd0:    return {24'b0, mem[b]};
         2'd1:    return {16'b0, mem[b+12'd1], mem[b]};
         default: return {mem[b+12'd3], mem[b+12'd2], mem[b+12'd1], mem[b]};
      endcase
   endfunction

   // bench memory and per-clock beat comparison (R7)
   always @(negedge clk) begin
      if (rst_n && mem_valid) begin
         if (!mem_we) mem_rdata <= rmem(mem_addr, mem_size);
         else begin
            logic [11:0] b = mem_addr[11:0];
            mem[b] = mem_wdata[7:0];
            if (mem_size >= 2'd1) mem[b+12'd1] = mem_wdata[15:8];
            if (mem_size == 2'd2) begin
               mem[b+12'd2] = mem_wdata[23:16];
               mem[b+12'd3] = mem_wdata[31:24];
            end
            wcount++;
            if (track) begin
               if (expq.size() == 0) chk("R7 unexpected write beat", {mem_size, mem_addr[29:0], mem_wdata}, 64'h0);
               else chk("R7 write beat", {mem_size, mem_addr[29:0], mem_wdata}, expq.pop_front());
            end
         end
      end
   end

   task automatic wr(int a, logic [31:0] d);
      @(negedge clk);
      reg_we = 1'b1; reg_addr = a[RAW-1:2]; reg_wdata = d;
      @(negedge clk);
      reg_we = 1'b0;
   endtask

   task automatic rd(int a, output logic [31:0] d);
      @(negedge clk);
      reg_addr = a[RAW-1:2];
      #1 d = reg_rdata;
   endtask

   task automatic rchk(string tag, int a, logic [31:0] exp);
      logic [31:0] d;
      rd(a, d);
      chk(tag, d, exp);
   endtask

   function automatic int chb(int c);
      return ((c < 2) ? c : c + 1) * 16;
   endfunction

   task automatic prog(int c, int s, int d, int n, logic [31:0] ctl);
      wr(chb(c), s); wr(chb(c) + 4, d); wr(chb(c) + 8, n); wr(chb(c) + 12, ctl);
   endtask

   task automatic pushx(int s, int d, int sz, int n, bit si, bit di);
      int ub = (sz == 3) ? 16 : (1 << sz);
      for (int u = 0; u < n; u++) begin
         if (sz == 3) begin
            for (int k = 0; k < 4; k++)
               expq.push_back({2'd2, 30'(d + 4 * k), rmem(s + 4 * k, 2'd2)});
         end else expq.push_back({2'(sz), 30'(d), rmem(s, 2'(sz))});
         if (si) s += ub;
         if (di) d += ub;
      end
   endtask

   task automatic idle(int n);
      repeat (n) @(negedge clk);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         fails++; tests++;
         $display("FAIL watchdog expired");
         $display("  [TB] %0d tests run, %0d failed", tests, fails);
         $finish;
      end
   end

   initial begin
      int w0, n;
      logic [31:0] d;
      for (int i = 0; i < 4096; i++) mem[i] = 8'((i * 13) ^ (i >> 3) ^ 8'h5A);
      idle(3);
      rst_n = 1'b1;
      idle(1);
      // R1 reset state
      rchk("R1 ctrl ch0 reset", 12, 32'h320);
      rchk("R1 ctrl ch3 reset", 16'h4C, 32'h320);
      rchk("R1 op reset", 16'h20, 32'h0);
      rchk("R1 count reset", 8, 32'h0);
      chk("R1 irq reset", {end_irq, err_irq}, 0);

      // R2 slot map
      wr(16'h30, 32'h0000_0ABC);
      rchk("R2 ch2 src slot 0x30", 16'h30, 32'hABC);
      rchk("R2 ch1 src untouched", 16'h10, 32'h0);
      wr(16'h30, 0);

      // R3 R4 R5 basic word transfer with interrupt
      wr(16'h20, 1);
      pushx(16'h100, 16'h200, 2, 4, 1, 1);
      prog(0, 16'h100, 16'h200, 4, 32'h325);
      idle(30);
      chk("R7 queue drained basic", expq.size(), 0);
      rchk("R4 end flag set", 12, 32'h327);
      rchk("R3 count zero", 8, 0);
      rchk("R6 src advanced", 0, 32'h110);
      rchk("R6 dst advanced", 4, 32'h210);
      chk("R5 end irq high", end_irq, 4'b0001);
      wr(12, 32'h322);
      chk("R5 end irq cleared by IE", end_irq, 4'b0000);
      rchk("R4 end flag kept", 12, 32'h322);
      wr(chb(1) + 12, 32'h322);
      rchk("R4 write 1 to end flag ignored", chb(1) + 12, 32'h320);

      // R3 R6 byte units, destination held
      pushx(16'h101, 16'h300, 0, 3, 1, 0);
      prog(0, 16'h101, 16'h300, 3, 32'h101);
      idle(20);
      chk("R7 queue drained byte", expq.size(), 0);
      rchk("R6 byte src step", 0, 32'h104);
      rchk("R6 dst held", 4, 32'h300);
      rchk("R3 byte count zero", 8, 0);
      chk("R5 no irq when IE clear", end_irq, 4'b0000);

      // R6 sixteen-byte units
      pushx(16'h140, 16'h240, 3, 2, 1, 1);
      prog(0, 16'h140, 16'h240, 2, 32'h331);
      idle(30);
      chk("R7 queue drained 16B", expq.size(), 0);
      rchk("R6 16B src step", 0, 32'h160);
      rchk("R3 16B count", 8, 0);

      // R8 R9 priority and global enable gating
      wr(16'h20, 0);
      w0 = wcount;
      prog(3, 16'h010, 16'h2A0, 2, 32'h321);
      prog(1, 16'h000, 16'h280, 2, 32'h321);
      idle(15);
      chk("R9 no beats while disabled", wcount - w0, 0);
      pushx(16'h000, 16'h280, 2, 2, 1, 1);
      pushx(16'h010, 16'h2A0, 2, 2, 1, 1);
      wr(16'h20, 32'h7);
      rchk("R9 write 1 leaves flags clear", 16'h20, 32'h1);
      idle(30);
      chk("R8 queue drained priority", expq.size(), 0);

      // R10 R11 address error and restart
      prog(0, 16'h102, 16'h2C0, 2, 32'h321);
      idle(5);
      rchk("R10 op after misalign", 16'h20, 32'h4);
      chk("R10 err irq", err_irq, 1);
      rchk("R10 count untouched", 8, 2);
      w0 = wcount;
      prog(1, 16'h020, 16'h2E0, 1, 32'h321);
      idle(10);
      chk("R10 all channels blocked", wcount - w0, 0);
      wr(0, 16'h100);
      pushx(16'h100, 16'h2C0, 2, 2, 1, 1);
      pushx(16'h020, 16'h2E0, 2, 1, 1, 1);
      wr(16'h20, 1);
      idle(30);
      chk("R11 queue drained after restart", expq.size(), 0);
      rchk("R11 op running", 16'h20, 32'h1);
      chk("R11 err irq low", err_irq, 0);

      // R10 R11 event pulse
      @(negedge clk); nmi_in = 1'b1;
      @(negedge clk); nmi_in = 1'b0;
      rchk("R10 event flag", 16'h20, 32'h2);
      w0 = wcount;
      prog(2, 16'h030, 16'h310, 1, 32'h321);
      idle(10);
      chk("R10 blocked by event flag", wcount - w0, 0);
      pushx(16'h030, 16'h310, 2, 1, 1, 1);
      wr(16'h20, 1);
      idle(15);
      chk("R11 drained after event", expq.size(), 0);

      // R3 zero count means 2^CW units
      pushx(16'h000, 16'h3F0, 0, 256, 1, 0);
      prog(0, 16'h000, 16'h3F0, 0, 32'h101);
      idle(900);
      chk("R3 256 units drained", expq.size(), 0);
      rchk("R3 zero-count src", 0, 32'h100);
      rchk("R4 zero-count end flag", 12, 32'h103);

      // R12 enable cleared mid-transfer
      track = 1'b0;
      w0 = wcount;
      prog(0, 16'h000, 16'h400, 0, 32'h321);
      idle(30);
      wr(12, 32'h320);
      idle(10);
      n = wcount - w0;
      chk("R12 some units moved", (n > 0 && n < 256), 1);
      rchk("R12 remaining count", 8, 32'((256 - n) % 256));
      rchk("R12 dst matches units", 4, 32'(16'h400 + 4 * n));
      idle(20);
      chk("R12 no beats after stop", wcount - w0, n);

      done = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule